// File: doc/BRIEF.md
# Video Input Sync Status Monitor

This block sits beside a video decoder front end and condenses its timing strobes into one 8-bit status word. Once per line it learns whether a sync pulse was detected and where the horizontal sync landed compared with where it was expected. At each field end it learns how many lines the field held. From these it derives a video-present flag, a horizontal-lock flag and a 525/625 line-format flag, each with counted hysteresis over consecutive lines or fields. It also shows the current field parity and the PLL lock state as live bits.

Two bits are sticky: the chroma and luma ADC overflow flags latch on a single-cycle overflow pulse. They stay set until a register write clears them, or until reset. A write clears only the sticky bits whose data bit is 1. Writing has no effect on any live bit.

Top module: `vsync_status_mon`

## Requirements
- R1: During and after reset the status word reads 0x00 (with the PLL reported locked). Bit 3 always reads 0.
- R2: Bit 7 (video present) reads 1 in the cycle after any line strobe that has sync detected.
- R3: Bit 7 clears after 31 consecutive line strobes without sync. After 30 such strobes it still reads 1.
- R4: Bit 6 (H-lock) sets after 32 consecutive line strobes whose measured sync position is within ±1 sample of the expected position. A single out-of-window line restarts the count.
- R5: Once bit 6 is set, it clears only after 32 consecutive out-of-window lines. After 31 such lines it still reads 1.
- R6: A write leaves bits 7, 6, 5, 4 and 2 unchanged, whatever the write data.
- R7: Bit 5 follows the field-parity input one cycle later: 0 for an odd field, 1 for an even field.
- R8: Bit 4 reads 0 for the 525-line format and 1 for the 625-line format. It changes only after 32 consecutive field-end strobes that report the other format's line count. After 31 of them it has not yet changed.
- R9: A field-end line count that is neither 525 nor 625 restarts the consecutive-field count for bit 4.
- R10: Bit 0 (chroma overflow) and bit 1 (luma overflow) set in the cycle after their overflow pulse and hold with no further pulse.
- R11: A write clears each overflow bit whose write-data bit is 1 and leaves the other as it was. When an overflow pulse and a clearing write fall in the same cycle, the bit ends up set.
- R12: Bit 2 reads 1 when the PLL lock input is low and 0 when it is high, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_tick | input | 1 | One-cycle strobe per line period |
| sync_seen | input | 1 | Sync was detected in this line; valid with line_tick |
| hs_pos | input | 12 | Measured horizontal sync sample position; valid with line_tick |
| hs_exp | input | 12 | Expected horizontal sync sample position; valid with line_tick |
| field_end | input | 1 | One-cycle strobe at the end of each field |
| field_lines | input | 10 | Line count of the field just ended; valid with field_end |
| field_even | input | 1 | Parity of the field being decoded (1 = even) |
| chroma_ovf | input | 1 | Chroma ADC overflow pulse |
| luma_ovf | input | 1 | Luma ADC overflow pulse |
| pll_locked | input | 1 | PLL lock indication (1 = locked) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 1 in bit 0 or 1 clears that sticky flag |
| rd_data | output | 8 | Status word |

## Verification
The bench builds the block with its default parameters: a 31-line loss window, 32-line lock hysteresis, 32-field format hysteresis, a ±1 sample window and 12-bit positions. These values keep every threshold reachable within a few hundred cycles. The bench walks each counter to one short of its limit and then to the limit itself. It uses offsets of exactly +1, −1 and +2 samples to probe both edges of the sync window.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  localparam int STAT_W     = 8;
  localparam int B_CHROMA   = 0;
  localparam int B_LUMA     = 1;
  localparam int B_PLL_BAD  = 2;
  localparam int B_FMT625   = 4;
  localparam int B_FIELD    = 5;
  localparam int B_HLOCK    = 6;
  localparam int B_PRESENT  = 7;
endpackage

// File: rtl/vsm_presence.sv
module vsm_presence #(
  parameter int MISS_LINES = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_tick,
  input  logic sync_seen,
  output logic present
);
  localparam int CW = $clog2(MISS_LINES + 1);
  localparam logic [CW-1:0] LAST = CW'(MISS_LINES - 1);

  logic [CW-1:0] miss_q, miss_d;
  logic          pres_q, pres_d;
  logic          upd;

  always_comb begin
    upd    = line_tick;
    miss_d = miss_q;
    pres_d = pres_q;
    if (sync_seen) begin
      miss_d = '0;
      pres_d = 1'b1;
    end else if (miss_q == LAST) begin
      pres_d = 1'b0;
    end else begin
      miss_d = miss_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= '0;
      pres_q <= 1'b0;
    end else if (upd) begin
      miss_q <= miss_d;
      pres_q <= pres_d;
    end
  end

  assign present = pres_q;

  assert_sync_sets_present_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && sync_seen) |=> present);
  assert_present_falls_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(present) |-> $past(line_tick && !sync_seen));
endmodule

// File: rtl/vsm_hlock.sv
module vsm_hlock #(
  parameter int POS_W    = 12,
  parameter int TOL      = 1,
  parameter int LOCK_RUN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_tick,
  input  logic [POS_W-1:0] hs_pos,
  input  logic [POS_W-1:0] hs_exp,
  output logic             locked
);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [RW-1:0] LAST = RW'(LOCK_RUN - 1);
  localparam logic [POS_W-1:0] TOL_V = POS_W'(TOL);

  logic [RW-1:0] run_q, run_d;
  logic          lock_q, lock_d;
  logic          in_win;

  always_comb begin
    if (hs_pos >= hs_exp) in_win = (hs_pos - hs_exp) <= TOL_V;
    else                  in_win = (hs_exp - hs_pos) <= TOL_V;
    run_d  = '0;
    lock_d = lock_q;
    if (in_win != lock_q) begin
      if (run_q == LAST) lock_d = ~lock_q;
      else               run_d  = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (line_tick) begin
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;

  assert_hlock_moves_on_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> $stable(locked));
  assert_hlock_rise_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(line_tick));
endmodule

// File: rtl/vsm_format.sv
module vsm_format #(
  parameter int LC_W      = 10,
  parameter int LINES_A   = 525,
  parameter int LINES_B   = 625,
  parameter int FIELD_RUN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            field_end,
  input  logic [LC_W-1:0] field_lines,
  output logic            fmt_b
);
  localparam int FW = $clog2(FIELD_RUN + 1);
  localparam logic [FW-1:0]   LAST = FW'(FIELD_RUN - 1);
  localparam logic [LC_W-1:0] CNT_A = LC_W'(LINES_A);
  localparam logic [LC_W-1:0] CNT_B = LC_W'(LINES_B);

  logic [FW-1:0] run_q, run_d;
  logic          fmt_q, fmt_d;
  logic          is_a, is_b;

  always_comb begin
    is_a  = field_lines == CNT_A;
    is_b  = field_lines == CNT_B;
    run_d = '0;
    fmt_d = fmt_q;
    if ((is_b && !fmt_q) || (is_a && fmt_q)) begin
      if (run_q == LAST) fmt_d = ~fmt_q;
      else               run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      fmt_q <= 1'b0;
    end else if (field_end) begin
      run_q <= run_d;
      fmt_q <= fmt_d;
    end
  end

  assign fmt_b = fmt_q;

  assert_fmt_moves_on_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !field_end |=> $stable(fmt_b));
  assert_fmt_needs_valid_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && !is_a && !is_b) |=> $stable(fmt_b));
endmodule

// File: rtl/vsync_status_mon.sv
module vsync_status_mon #(
  parameter int POS_W      = 12,
  parameter int LC_W       = 10,
  parameter int SYNC_TOL   = 1,
  parameter int MISS_LINES = 31,
  parameter int LOCK_RUN   = 32,
  parameter int FIELD_RUN  = 32,
  parameter int LINES_A    = 525,
  parameter int LINES_B    = 625
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_tick,
  input  logic             sync_seen,
  input  logic [POS_W-1:0] hs_pos,
  input  logic [POS_W-1:0] hs_exp,
  input  logic             field_end,
  input  logic [LC_W-1:0]  field_lines,
  input  logic             field_even,
  input  logic             chroma_ovf,
  input  logic             luma_ovf,
  input  logic             pll_locked,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data
);
  import vsm_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic present, locked, fmt_b;

  vsm_presence #(.MISS_LINES(MISS_LINES)) u_pres (
    .clk(clk), .rst_n(rst_i_n), .line_tick(line_tick),
    .sync_seen(sync_seen), .present(present));

  vsm_hlock #(.POS_W(POS_W), .TOL(SYNC_TOL), .LOCK_RUN(LOCK_RUN)) u_hlock (
    .clk(clk), .rst_n(rst_i_n), .line_tick(line_tick),
    .hs_pos(hs_pos), .hs_exp(hs_exp), .locked(locked));

  vsm_format #(.LC_W(LC_W), .LINES_A(LINES_A), .LINES_B(LINES_B),
               .FIELD_RUN(FIELD_RUN)) u_fmt (
    .clk(clk), .rst_n(rst_i_n), .field_end(field_end),
    .field_lines(field_lines), .fmt_b(fmt_b));

  logic chroma_q, chroma_d, luma_q, luma_d;
  logic field_q, pll_bad_q;
  logic clr_chroma, clr_luma;

  always_comb begin
    clr_chroma = wr_en && wr_data[B_CHROMA];
    clr_luma   = wr_en && wr_data[B_LUMA];
    chroma_d   = (chroma_q && !clr_chroma) || chroma_ovf;
    luma_d     = (luma_q && !clr_luma) || luma_ovf;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      chroma_q  <= 1'b0;
      luma_q    <= 1'b0;
      field_q   <= 1'b0;
      pll_bad_q <= 1'b0;
    end else begin
      chroma_q  <= chroma_d;
      luma_q    <= luma_d;
      field_q   <= field_even;
      pll_bad_q <= !pll_locked;
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[B_CHROMA]  = chroma_q;
    rd_data[B_LUMA]    = luma_q;
    rd_data[B_PLL_BAD] = pll_bad_q;
    rd_data[B_FMT625]  = fmt_b;
    rd_data[B_FIELD]   = field_q;
    rd_data[B_HLOCK]   = locked;
    rd_data[B_PRESENT] = present;
  end

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_data[3] == 1'b0);
  assert_chroma_pulse_sets_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    chroma_ovf |=> rd_data[B_CHROMA]);
  assert_chroma_holds_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_data[B_CHROMA] && !(wr_en && wr_data[B_CHROMA])) |=> rd_data[B_CHROMA]);
  assert_luma_holds_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_data[B_LUMA] && !(wr_en && wr_data[B_LUMA])) |=> rd_data[B_LUMA]);
  assert_pll_follows_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    !pll_locked |=> rd_data[B_PLL_BAD]);
endmodule

// File: tb/tb_vsync_status_mon.sv
module tb_vsync_status_mon;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_tick, sync_seen, field_end, field_even;
  logic [11:0] hs_pos, hs_exp;
  logic [9:0]  field_lines;
  logic        chroma_ovf, luma_ovf, pll_locked, wr_en;
  logic [7:0]  wr_data, rd_data;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  vsync_status_mon dut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .sync_seen(sync_seen),
    .hs_pos(hs_pos), .hs_exp(hs_exp), .field_end(field_end),
    .field_lines(field_lines), .field_even(field_even),
    .chroma_ovf(chroma_ovf), .luma_ovf(luma_ovf), .pll_locked(pll_locked),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bitchk(input string req, input int b, input logic exp);
    check(req, {7'b0, rd_data[b]}, {7'b0, exp});
  endtask

  task automatic line(input bit sync, input int off);
    @(negedge clk);
    line_tick = 1'b1; sync_seen = sync;
    hs_exp = 12'd800; hs_pos = 12'(800 + off);
    @(negedge clk);
    line_tick = 1'b0; sync_seen = 1'b0;
  endtask

  task automatic field(input int n);
    @(negedge clk);
    field_end = 1'b1; field_lines = 10'(n);
    @(negedge clk);
    field_end = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", rd_data, 8'h00);
  endtask

  task automatic t_presence;
    line(1'b1, 5);
    bitchk("R2 present after sync line", 7, 1'b1);
    for (int i = 0; i < 30; i++) line(1'b0, 5);
    bitchk("R3 present after 30 missed lines", 7, 1'b1);
    line(1'b0, 5);
    bitchk("R3 present cleared after 31 missed lines", 7, 1'b0);
    line(1'b1, 5);
    bitchk("R2 present back on sync", 7, 1'b1);
  endtask

  task automatic t_hlock;
    for (int i = 0; i < 31; i++) line(1'b1, 1);
    bitchk("R4 no lock after 31 lines", 6, 1'b0);
    line(1'b1, 2);
    for (int i = 0; i < 31; i++) line(1'b1, (i % 2 == 0) ? -1 : 0);
    bitchk("R4 miss restarted the run", 6, 1'b0);
    line(1'b1, 1);
    bitchk("R4 lock after 32 in-window lines", 6, 1'b1);
    wr(8'hFF);
    bitchk("R6 write leaves hlock", 6, 1'b1);
    bitchk("R6 write leaves present", 7, 1'b1);
    for (int i = 0; i < 31; i++) line(1'b1, (i % 2 == 0) ? 2 : -3);
    bitchk("R5 lock held after 31 misses", 6, 1'b1);
    line(1'b1, 2);
    bitchk("R5 lock dropped after 32 misses", 6, 1'b0);
  endtask

  task automatic t_field;
    @(negedge clk); field_even = 1'b1;
    @(negedge clk);
    bitchk("R7 even field", 5, 1'b1);
    wr(8'hFF);
    bitchk("R6 write leaves field", 5, 1'b1);
    field_even = 1'b0;
    @(negedge clk);
    bitchk("R7 odd field", 5, 1'b0);
  endtask

  task automatic t_format;
    for (int i = 0; i < 31; i++) field(625);
    bitchk("R8 still 525 after 31 fields", 4, 1'b0);
    field(700);
    for (int i = 0; i < 31; i++) field(625);
    bitchk("R9 odd count restarted run", 4, 1'b0);
    field(625);
    bitchk("R8 switched to 625", 4, 1'b1);
    wr(8'hFF);
    bitchk("R6 write leaves format", 4, 1'b1);
    for (int i = 0; i < 31; i++) field(525);
    bitchk("R8 still 625 after 31 fields", 4, 1'b1);
    field(525);
    bitchk("R8 back to 525", 4, 1'b0);
  endtask

  task automatic t_sticky;
    @(negedge clk); chroma_ovf = 1'b1;
    @(negedge clk); chroma_ovf = 1'b0;
    bitchk("R10 chroma set", 0, 1'b1);
    repeat (5) @(negedge clk);
    bitchk("R10 chroma held", 0, 1'b1);
    @(negedge clk); luma_ovf = 1'b1;
    @(negedge clk); luma_ovf = 1'b0;
    bitchk("R10 luma set", 1, 1'b1);
    wr(8'h01);
    bitchk("R11 chroma cleared", 0, 1'b0);
    bitchk("R11 luma kept", 1, 1'b1);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h02; luma_ovf = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0; luma_ovf = 1'b0;
    bitchk("R11 set wins over clear", 1, 1'b1);
    wr(8'h02);
    bitchk("R11 luma cleared", 1, 1'b0);
    check("R1 reserved bit", {7'b0, rd_data[3]}, 8'h00);
  endtask

  task automatic t_pll;
    @(negedge clk); pll_locked = 1'b0;
    @(negedge clk);
    bitchk("R12 unlocked shows 1", 2, 1'b1);
    wr(8'h04);
    bitchk("R6 write leaves pll bit", 2, 1'b1);
    pll_locked = 1'b1;
    @(negedge clk);
    bitchk("R12 locked shows 0", 2, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    line_tick = 0; sync_seen = 0; hs_pos = '0; hs_exp = '0;
    field_end = 0; field_lines = '0; field_even = 0;
    chroma_ovf = 0; luma_ovf = 0; pll_locked = 1; wr_en = 0; wr_data = '0;
    t_reset();
    t_presence();
    t_hlock();
    t_field();
    t_format();
    t_sticky();
    t_pll();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule